// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a down-counting watchdog that must run out twice before it asks for a system reset. The first time the count reaches zero it raises a critical interrupt. Software can use that interrupt to save crash data and acknowledge it. If software does not service the timer before the next run-out, the block drives an active-low reset request. It does so only when the reset-request enable has been set.

The reset-request enable is sticky. Software can set it through the write port, and any attempt to clear it is ignored. Only the block's reset returns it to zero, so runaway code cannot switch the reset path off. The reset request also stays asserted until the block is reset. All software access goes through one write port with a 2-bit selector: service/reload, period, control and interrupt acknowledge.

Top module: `two_stage_wdt`

## Requirements
- R1: After reset the interrupt is low, the reset request is high (inactive), the enable is clear, the stage is zero and the counter holds PERIOD_RST.
- R2: The counter decrements once per cycle. When it reaches zero it expires on the next edge and reloads from the period register, so an interval lasts period+1 cycles.
- R3: An expiry while the stage is zero sets the stage and raises crit_irq_o.
- R4: An expiry while the stage is one, with the enable set, drives rst_req_no low.
- R5: An expiry while the stage is one, with the enable clear, leaves rst_req_no high and the stage at one.
- R6: A service write (selector 0) reloads the counter from the period register and returns the stage to zero. It takes precedence over an expiry in the same cycle, which is then suppressed.
- R7: A period write (selector 1) stores wr_data_i. The new value is used from the next reload onward.
- R8: A control write (selector 2) with data bit 0 set sets the enable. A control write with bit 0 clear has no effect on it.
- R9: crit_irq_o stays high until an acknowledge write (selector 3) with data bit 0 set. If an expiry in stage zero falls in the same cycle as the acknowledge, the interrupt stays high.
- R10: Once low, rst_req_no stays low until rst_ni is asserted. Service and acknowledge writes do not release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 2 | Write target: 0 service, 1 period, 2 control, 3 acknowledge |
| wr_data_i | input | CNT_W | Write data; bit 0 is used by control and acknowledge |
| crit_irq_o | output | 1 | Critical interrupt from the first expiry |
| rst_req_no | output | 1 | Active-low reset request from the second expiry |

## Verification
Two pairs of events can land on the same edge. One pair is a stage-zero expiry and an interrupt acknowledge. The other is an expiry and a service write. The bench waits until its reference model shows the counter at zero, then drives the acknowledge or the service write for exactly that edge. The bench judges the result on the following cycle. After the acknowledge collision the interrupt must still be high. After the service collision the interrupt must stay low and the next interval must run a full period.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WSEL_SERVICE = 2'd0,
    WSEL_PERIOD  = 2'd1,
    WSEL_CTRL    = 2'd2,
    WSEL_ACK     = 2'd3
  } wsel_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PERIOD_RST = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] period_o,
  output logic             rst_en_o,
  output logic             service_o,
  output logic             ack_o
);
  import wdt_pkg::*;

  localparam logic [CNT_W-1:0] PeriodInit = CNT_W'(PERIOD_RST);

  wsel_e sel;
  assign sel = wsel_e'(wr_sel_i);

  logic [CNT_W-1:0] period_q;
  logic             rst_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= PeriodInit;
      rst_en_q <= 1'b0;
    end else if (wr_en_i) begin
      if (sel == WSEL_PERIOD) period_q <= wr_data_i;
      // set-only: a zero in bit 0 leaves the enable untouched
      if (sel == WSEL_CTRL && wr_data_i[0]) rst_en_q <= 1'b1;
    end
  end

  assign period_o  = period_q;
  assign rst_en_o  = rst_en_q;
  assign service_o = wr_en_i && (sel == WSEL_SERVICE);
  assign ack_o     = wr_en_i && (sel == WSEL_ACK) && wr_data_i[0];

  p_sticky_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_en_q |=> rst_en_q);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PERIOD_RST = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             service_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             expire_o
);
  localparam logic [CNT_W-1:0] PeriodInit = CNT_W'(PERIOD_RST);

  logic [CNT_W-1:0] cnt_q;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  assign expire_o = at_zero && !service_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= PeriodInit;
    else if (service_i || at_zero) cnt_q <= period_i;
    else                           cnt_q <= cnt_q - 1'b1;
  end

  p_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> (cnt_q == $past(period_i)));
  p_service_reload_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    service_i |=> (cnt_q == $past(period_i)));
endmodule

// File: rtl/wdt_stage.sv
module wdt_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic service_i,
  input  logic ack_i,
  input  logic rst_en_i,
  output logic crit_irq_o,
  output logic rst_req_no
);
  logic stage_q, irq_q, req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 1'b0;
      irq_q   <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      if (service_i)     stage_q <= 1'b0;
      else if (expire_i) stage_q <= 1'b1;
      // a new first expiry wins over a same-cycle acknowledge
      if (expire_i && !stage_q) irq_q <= 1'b1;
      else if (ack_i)           irq_q <= 1'b0;
      if (expire_i && stage_q && rst_en_i) req_q <= 1'b1;
    end
  end

  assign crit_irq_o = irq_q;
  assign rst_req_no = ~req_q;

  p_first_expiry_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && !stage_q) |=> (stage_q && crit_irq_o));
  p_service_stage_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    service_i |=> !stage_q);
  p_irq_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (crit_irq_o && !ack_i) |=> crit_irq_o);
  p_req_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_req_no) |-> ($past(stage_q) && $past(rst_en_i) && $past(expire_i)));
  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_req_no |=> !rst_req_no);
endmodule

// File: rtl/two_stage_wdt.sv
module two_stage_wdt #(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned PERIOD_RST = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             crit_irq_o,
  output logic             rst_req_no
);
  logic [CNT_W-1:0] period;
  logic             rst_en, service, ack, expire;

  wdt_regs #(.CNT_W(CNT_W), .PERIOD_RST(PERIOD_RST)) i_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_sel_i, .wr_data_i,
    .period_o (period),
    .rst_en_o (rst_en),
    .service_o(service),
    .ack_o    (ack)
  );

  wdt_counter #(.CNT_W(CNT_W), .PERIOD_RST(PERIOD_RST)) i_counter (
    .clk_i, .rst_ni,
    .service_i(service),
    .period_i (period),
    .expire_o (expire)
  );

  wdt_stage i_stage (
    .clk_i, .rst_ni,
    .expire_i  (expire),
    .service_i (service),
    .ack_i     (ack),
    .rst_en_i  (rst_en),
    .crit_irq_o,
    .rst_req_no
  );
endmodule

// File: tb/test_two_stage_wdt.sv
module test_two_stage_wdt;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int PERIOD_RST = 12;
  localparam int WATCHDOG   = 100000;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [1:0]       wr_sel_i = 2'd0;
  logic [CNT_W-1:0] wr_data_i = '0;
  logic             crit_irq_o, rst_req_no;

  int total = 0, bad = 0, cycles = 0;
  string tag = "R1";

  // reference model state
  int m_cnt, m_period, m_stage, m_irq, m_req, m_en;

  two_stage_wdt #(.CNT_W(CNT_W), .PERIOD_RST(PERIOD_RST)) i_two_stage_wdt (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = PERIOD_RST; m_period = PERIOD_RST;
      m_stage = 0; m_irq = 0; m_req = 0; m_en = 0;
    end else begin
      bit svc, ack, exp;
      int old_stage, old_en;
      svc = wr_en_i && wr_sel_i == 2'd0;
      ack = wr_en_i && wr_sel_i == 2'd3 && wr_data_i[0];
      exp = (m_cnt == 0) && !svc;
      old_stage = m_stage; old_en = m_en;
      if (svc || m_cnt == 0) m_cnt = m_period; else m_cnt = m_cnt - 1;
      if (svc) m_stage = 0; else if (exp) m_stage = 1;
      if (exp && old_stage == 0) m_irq = 1; else if (ack) m_irq = 0;
      if (exp && old_stage == 1 && old_en == 1) m_req = 1;
      if (wr_en_i && wr_sel_i == 2'd1) m_period = int'(wr_data_i);
      if (wr_en_i && wr_sel_i == 2'd2 && wr_data_i[0]) m_en = 1;
    end
  end

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string t, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", t, act, exp, cycles);
    end
  endtask

  // one clock; compare with model at the following falling edge
  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    chk({tag, " irq"}, int'(crit_irq_o), m_irq);
    chk({tag, " req"}, int'(!rst_req_no), m_req);
  endtask

  task automatic wr(int sel, int data);
    wr_en_i = 1'b1; wr_sel_i = 2'(sel); wr_data_i = CNT_W'(data);
    tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic to_zero();
    while (m_cnt != 0) tick();
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    do_reset();
    tag = "R1";
    chk("R1 irq after reset", int'(crit_irq_o), 0);
    chk("R1 req after reset", int'(rst_req_no), 1);
    // R2: expiry on the 13th edge after reset
    tag = "R2";
    idle(PERIOD_RST);
    chk("R2 no irq before expiry", int'(crit_irq_o), 0);
    tag = "R3";
    tick();
    chk("R3 irq on first expiry", int'(crit_irq_o), 1);
    tag = "R9";
    idle(3);
    chk("R9 irq held", int'(crit_irq_o), 1);
    wr(3, 0);
    chk("R9 ack bit0=0 ignored", int'(crit_irq_o), 1);
    wr(3, 1);
    chk("R9 irq cleared by ack", int'(crit_irq_o), 0);
    // R5: second expiry without enable
    tag = "R5";
    to_zero(); tick();
    chk("R5 no req without enable", int'(rst_req_no), 1);
    idle(2 * PERIOD_RST + 4);
    chk("R5 irq not re-raised in stage 1", int'(crit_irq_o), 0);
    // R8: set enable, try to clear it
    tag = "R8";
    wr(2, 1);
    wr(2, 0);
    // R7: new period applies at next reload
    tag = "R7";
    wr(1, 5);
    wr(0, 0);
    tag = "R6";
    chk("R6 service leaves req inactive", int'(rst_req_no), 1);
    tag = "R7";
    idle(5);
    chk("R7 no expiry within new period", int'(crit_irq_o), 0);
    tick();
    chk("R7 expiry after period 5", int'(crit_irq_o), 1);
    // R9: ack in the same edge as a stage-zero expiry
    tag = "R9";
    wr(3, 1);
    wr(0, 0);
    to_zero();
    wr(3, 1);
    chk("R9 expiry beats same-cycle ack", int'(crit_irq_o), 1);
    wr(3, 1);
    // R6: service on the expiry edge suppresses it
    tag = "R6";
    wr(0, 0);
    to_zero();
    wr(0, 0);
    chk("R6 service beats expiry", int'(crit_irq_o), 0);
    idle(5);
    chk("R6 full period after collision", int'(crit_irq_o), 0);
    // R4/R8: two expiries with sticky enable still set
    tag = "R4";
    to_zero(); tick();
    chk("R4 first expiry irq", int'(crit_irq_o), 1);
    to_zero(); tick();
    chk("R4 R8 req asserted with sticky enable", int'(rst_req_no), 0);
    tag = "R10";
    wr(0, 0);
    wr(3, 1);
    idle(20);
    chk("R10 req held after service and ack", int'(rst_req_no), 0);
    // R1/R8: reset clears the request and the enable
    tag = "R1";
    do_reset();
    chk("R1 R10 req released by reset", int'(rst_req_no), 1);
    tag = "R8";
    idle(PERIOD_RST + 1);
    chk("R8 irq after reset", int'(crit_irq_o), 1);
    to_zero(); tick();
    chk("R8 enable cleared by reset", int'(rst_req_no), 1);
    idle(4);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule